// File: doc/BRIEF.md
# Card Supply Sequencing Controller

This controller decides when a smart card's supply and contacts are powered. It sits between a host and the analog front end on the card side. The host drives three control inputs. `stop_n` is an asynchronous kill line, also used to signal that the card has been removed. `vsel_3v` chooses the supply level. `pwr_req` asks for power. From these the block drives the card-line pass enables, the charge-pump enable and its two pump phase clocks, the battery bypass switch, the supply discharge pull-down and a ready flag.

A power request starts the supply at the level that was latched while power was off. The ready flag comes up only once a stabilization delay has run out. Power is removed either by dropping `pwr_req` or by pulling `stop_n` low. In both cases the contacts shut down in a fixed order, with a programmable step interval between steps: reset first, then clock, then data, then the supply. After that the discharge pull-down stays on for a minimum off-time, and a new power request is not served until that time has passed. At 5 V the pump clocks run with dead time between the two phases. At 3 V the pump is idle and the bypass switch feeds the card straight from the battery.

Top module: `card_supply_seq`

## Requirements
- R1: While `stop_n` is low, `rst_en`, `clk_en` and `dat_en` are 0 at once, without waiting for a clock edge. The synchronized stop starts the shutdown order, and the supply stays off whatever `pwr_req` does. After `stop_n` rises, with `pwr_req` high and the lockout expired, the supply comes back on the 3rd clock edge.
- R2: With `stop_n` high and `pwr_req` low the block is powered down. `pump_en`, `bypass_en`, `rst_en`, `clk_en`, `dat_en` and `ready` are all 0. The same holds straight after reset.
- R3: `vsel_3v` (0 = 5 V, 1 = 3 V) is sampled only while powered down. A change while powered has no effect on `pump_en` or `bypass_en` until the next power cycle.
- R4: With no lockout running, a power request drives `rst_en`, `clk_en` and `dat_en` to 1 on the first clock edge. On that same edge it drives `pump_en` (5 V) or `bypass_en` (3 V) to 1. After reset the latched level is 5 V.
- R5: When `pwr_req` falls, `rst_en` drops 1 edge later, `clk_en` after 1+S edges, `dat_en` after 1+2S edges and the supply after 1+3S edges, where S = STEP_CYC. If `host_clk` is low when the clock step falls due, `clk_en` and `dat_en` drop together after 1+S edges and the supply after 1+2S edges.
- R6: `discharge` rises on the edge that switches the supply off and stays high for OFF_CYC cycles (OFF_US microseconds at CLK_HZ). A `pwr_req` held high through that window powers the supply one edge after `discharge` falls, and not before.
- R7: At 5 V `bypass_en` is 0. `pump_ph1` and `pump_ph2` each run with period CLK_HZ/PUMP_HZ cycles. They are never high together, and neither rises in the cycle after the other was high.
- R8: At 3 V `bypass_en` is 1, and `pump_en`, `pump_ph1` and `pump_ph2` stay 0.
- R9: `ready` rises STAB_CYC edges after the power-up edge, and only while the supply is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stop_n | input | 1 | Asynchronous stop / card-removed, active low |
| vsel_3v | input | 1 | Supply level select: 0 = 5 V, 1 = 3 V |
| pwr_req | input | 1 | Power-on request |
| host_clk | input | 1 | Host card-clock level, used to skip the clock step |
| rst_en | output | 1 | Card reset line pass enable (0 = forced low) |
| clk_en | output | 1 | Card clock line pass enable (0 = forced low) |
| dat_en | output | 1 | Card data line pass enable (0 = forced low) |
| pump_en | output | 1 | Charge pump enable (5 V level) |
| pump_ph1 | output | 1 | Pump phase clock 1 |
| pump_ph2 | output | 1 | Pump phase clock 2 |
| bypass_en | output | 1 | Battery bypass switch (3 V level) |
| discharge | output | 1 | Supply discharge pull-down / lockout window |
| ready | output | 1 | Supply stabilized |

## Verification
The bench drives every input on a falling edge and samples on later falling edges. That makes the n-th sample show exactly the result of n rising edges. A power request is due at sample 1 and ready at sample STAB_CYC+1. The shutdown steps are due at samples 1, 1+S, 1+2S and 1+3S, or at 3+3S when stop is the trigger, because of the two synchronizer flops. The re-power is due one sample after `discharge` falls. For each result the bench records the first sample at which it appears and compares that index with the figure worked out from the parameters. The immediate effect of stop on the line enables is checked a fraction of a cycle after the drive, before any edge.

// File: rtl/card_supply_seq.sv
module card_supply_seq #(
  parameter int CLK_HZ   = 48_000_000,
  parameter int PUMP_HZ  = 800_000,
  parameter int STEP_CYC = 16,
  parameter int OFF_US   = 350,
  parameter int STAB_US  = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  input  logic vsel_3v,
  input  logic pwr_req,
  input  logic host_clk,
  output logic rst_en,
  output logic clk_en,
  output logic dat_en,
  output logic pump_en,
  output logic pump_ph1,
  output logic pump_ph2,
  output logic bypass_en,
  output logic discharge,
  output logic ready
);
  localparam int MHZ       = CLK_HZ / 1_000_000;
  localparam int OFF_CYC   = MHZ * OFF_US;
  localparam int STAB_CYC  = MHZ * STAB_US;
  localparam int PUMP_PER  = CLK_HZ / PUMP_HZ;
  localparam int PUMP_HALF = PUMP_PER / 2;
  localparam int OW = $clog2(OFF_CYC + 1);
  localparam int BW = $clog2(STAB_CYC + 1);
  localparam int SW = $clog2(STEP_CYC + 1);
  localparam int PW = $clog2(PUMP_PER + 1);

  typedef enum logic [1:0] {S_OFF, S_ON, S_DOWN} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic          stop_s;
  logic          r_q, c_q, d_q, sup_q, vsel_q;
  logic [1:0]    stage;
  logic [SW-1:0] step_cnt;
  logic [OW-1:0] off_cnt;
  logic [BW-1:0] stab_cnt;
  logic [PW-1:0] ph_cnt;

  assign stop_s    = sync[1];
  assign rst_en    = r_q & stop_n;
  assign clk_en    = c_q & stop_n;
  assign dat_en    = d_q & stop_n;
  assign pump_en   = sup_q & ~vsel_q;
  assign bypass_en = sup_q & vsel_q;
  assign discharge = (off_cnt != '0);
  assign ready     = (st == S_ON) && (stab_cnt == '0);
  assign pump_ph1  = pump_en && (ph_cnt != '0) && (ph_cnt < PW'(PUMP_HALF));
  assign pump_ph2  = pump_en && (ph_cnt > PW'(PUMP_HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b00;
      st       <= S_OFF;
      r_q      <= 1'b0;
      c_q      <= 1'b0;
      d_q      <= 1'b0;
      sup_q    <= 1'b0;
      vsel_q   <= 1'b0;
      stage    <= 2'd0;
      step_cnt <= '0;
      off_cnt  <= '0;
      stab_cnt <= '0;
    end else begin
      sync <= {sync[0], stop_n};
      if (off_cnt != '0) off_cnt <= off_cnt - 1'b1;
      case (st)
        S_OFF: begin
          vsel_q <= vsel_3v;
          if (off_cnt == '0 && pwr_req && stop_s) begin
            st       <= S_ON;
            r_q      <= 1'b1;
            c_q      <= 1'b1;
            d_q      <= 1'b1;
            sup_q    <= 1'b1;
            stab_cnt <= BW'(STAB_CYC);
          end
        end
        S_ON: begin
          if (stab_cnt != '0) stab_cnt <= stab_cnt - 1'b1;
          if (!pwr_req || !stop_s) begin
            st       <= S_DOWN;
            r_q      <= 1'b0;
            stage    <= 2'd0;
            step_cnt <= SW'(STEP_CYC - 1);
          end
        end
        S_DOWN: begin
          if (step_cnt != '0) step_cnt <= step_cnt - 1'b1;
          else begin
            step_cnt <= SW'(STEP_CYC - 1);
            case (stage)
              2'd0: begin
                c_q <= 1'b0;
                if (!host_clk) begin
                  d_q   <= 1'b0;
                  stage <= 2'd2;
                end else stage <= 2'd1;
              end
              2'd1: begin
                d_q   <= 1'b0;
                stage <= 2'd2;
              end
              default: begin
                sup_q   <= 1'b0;
                st      <= S_OFF;
                off_cnt <= OW'(OFF_CYC);
              end
            endcase
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ph_cnt <= '0;
    else if (!pump_en)                         ph_cnt <= '0;
    else if (ph_cnt == PW'(PUMP_PER - 1))      ph_cnt <= '0;
    else                                       ph_cnt <= ph_cnt + 1'b1;
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pump_ph1 && pump_ph2)); // R7
  AST_DEAD_PH2: assert property (@(posedge clk) disable iff (!rst_n) $rose(pump_ph2) |-> !$past(pump_ph1)); // R7
  AST_DEAD_PH1: assert property (@(posedge clk) disable iff (!rst_n) $rose(pump_ph1) |-> !$past(pump_ph2)); // R7
  AST_NO_PUMP_3V: assert property (@(posedge clk) disable iff (!rst_n) bypass_en |-> !pump_ph1 && !pump_ph2); // R8
  AST_VSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sup_q && $past(sup_q)) |-> $stable(vsel_q)); // R3
  AST_CLK_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n) $fell(c_q) |-> !r_q); // R5
  AST_DAT_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n) $fell(d_q) |-> !c_q); // R5
  AST_SUP_AFTER_DAT: assert property (@(posedge clk) disable iff (!rst_n) $fell(sup_q) |-> !d_q && discharge); // R5
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n) $rose(sup_q) |-> !$past(discharge)); // R6
  AST_READY_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (pump_en || bypass_en)); // R9
endmodule

// File: tb/card_supply_seq_tb.sv
module card_supply_seq_tb;
  localparam int CLK_HZ   = 8_000_000;
  localparam int PUMP_HZ  = 800_000;
  localparam int S        = 4;
  localparam int OFF_US   = 350;
  localparam int STAB_US  = 100;
  localparam int OFF_CYC  = (CLK_HZ / 1_000_000) * OFF_US;
  localparam int STAB_CYC = (CLK_HZ / 1_000_000) * STAB_US;
  localparam int PER      = CLK_HZ / PUMP_HZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_n = 1'b1, vsel_3v = 1'b0, pwr_req = 1'b0, host_clk = 1'b1;
  logic rst_en, clk_en, dat_en, pump_en, pump_ph1, pump_ph2, bypass_en, discharge, ready;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  card_supply_seq #(.CLK_HZ(CLK_HZ), .PUMP_HZ(PUMP_HZ), .STEP_CYC(S),
                    .OFF_US(OFF_US), .STAB_US(STAB_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .vsel_3v(vsel_3v), .pwr_req(pwr_req),
    .host_clk(host_clk), .rst_en(rst_en), .clk_en(clk_en), .dat_en(dat_en),
    .pump_en(pump_en), .pump_ph1(pump_ph1), .pump_ph2(pump_ph2), .bypass_en(bypass_en),
    .discharge(discharge), .ready(ready));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int outs();
    return {rst_en, clk_en, dat_en, pump_en, bypass_en, ready};
  endfunction

  // records first sample index of each shutdown event after the trigger
  task automatic run_down(input int lim, input bit rearm,
                          output int tr, output int tc, output int td, output int ts,
                          output int tdh, output int tdl, output int ton);
    tr = 0; tc = 0; td = 0; ts = 0; tdh = 0; tdl = 0; ton = 0;
    for (int n = 1; n <= lim; n++) begin
      @(negedge clk);
      if (tr == 0 && !rst_en) tr = n;
      if (tc == 0 && !clk_en) tc = n;
      if (td == 0 && !dat_en) td = n;
      if (tdh == 0 && discharge) tdh = n;
      if (tdh != 0 && tdl == 0 && !discharge) tdl = n;
      if (ts != 0 && ton == 0 && (pump_en || bypass_en)) ton = n;
      if (ts == 0 && !(pump_en || bypass_en)) begin
        ts = n;
        if (rearm) pwr_req = 1'b1;
      end
      if (ton != 0) break;
    end
  endtask

  task automatic t_reset;
    check("R2 reset outputs", outs(), 0);
    check("R2 reset discharge", discharge, 0);
    cycles(5);
    vsel_3v = 1'b1; cycles(3); vsel_3v = 1'b0; cycles(3);
    check("R2 powered-down outputs", outs(), 0);
  endtask

  task automatic t_power_on_5v;
    int tready = 0;
    pwr_req = 1'b1;
    @(negedge clk);
    check("R4 lines enabled", {rst_en, clk_en, dat_en}, 3'b111);
    check("R4 pump on at 5V", {pump_en, bypass_en}, 2'b10);
    check("R9 not ready at once", ready, 0);
    for (int n = 2; n <= STAB_CYC + 5; n++) begin
      @(negedge clk);
      if (tready == 0 && ready) tready = n;
    end
    check("R9 ready delay", tready, STAB_CYC + 1);
  endtask

  task automatic t_pump_5v;
    int h1 = 0, h2 = 0, both = 0, r1 = 0, adj = 0;
    logic p1 = pump_ph1, p2 = pump_ph2;
    for (int n = 0; n < 4 * PER; n++) begin
      @(negedge clk);
      h1 += pump_ph1; h2 += pump_ph2;
      if (pump_ph1 && pump_ph2) both++;
      if (pump_ph1 && !p1) r1++;
      if ((pump_ph2 && !p2 && p1) || (pump_ph1 && !p1 && p2)) adj++;
      p1 = pump_ph1; p2 = pump_ph2;
    end
    check("R7 phases overlap", both, 0);
    check("R7 no dead time", adj, 0);
    check("R7 ph1 rises per period", r1, 4);
    check("R7 ph1 high cycles", h1, 4 * (PER / 2 - 1));
    check("R7 ph2 high cycles", h2, 4 * (PER - PER / 2 - 1));
    check("R7 bypass open at 5V", bypass_en, 0);
  endtask

  task automatic t_vsel_locked;
    vsel_3v = 1'b1;
    cycles(40);
    check("R3 select ignored while powered", {pump_en, bypass_en}, 2'b10);
  endtask

  task automatic t_down_by_req;
    int tr, tc, td, ts, tdh, tdl, ton;
    pwr_req = 1'b0;
    run_down(3 * S + OFF_CYC + 20, 1'b1, tr, tc, td, ts, tdh, tdl, ton);
    check("R5 reset step", tr, 1);
    check("R5 clock step", tc, 1 + S);
    check("R5 data step", td, 1 + 2 * S);
    check("R5 supply step", ts, 1 + 3 * S);
    check("R6 discharge rises with supply off", tdh, 1 + 3 * S);
    check("R6 discharge window", tdl - tdh, OFF_CYC);
    check("R6 re-power after lockout", ton, tdl + 1);
    check("R3 new level latched at 3V", {pump_en, bypass_en}, 2'b01);
  endtask

  task automatic t_3v;
    int ph = 0;
    for (int n = 0; n < 3 * PER; n++) begin
      @(negedge clk);
      ph += pump_ph1 + pump_ph2 + pump_en;
    end
    check("R8 pump idle at 3V", ph, 0);
    check("R8 bypass closed", bypass_en, 1);
  endtask

  task automatic t_down_clk_low;
    int tr, tc, td, ts, tdh, tdl, ton;
    host_clk = 1'b0;
    pwr_req = 1'b0;
    run_down(3 * S + OFF_CYC + 20, 1'b0, tr, tc, td, ts, tdh, tdl, ton);
    check("R5 clk-low reset step", tr, 1);
    check("R5 clk-low clock step", tc, 1 + S);
    check("R5 clk-low data with clock", td, 1 + S);
    check("R5 clk-low supply step", ts, 1 + 2 * S);
    check("R6 clk-low discharge window", tdl - tdh, OFF_CYC);
    host_clk = 1'b1;
    vsel_3v = 1'b0;
  endtask

  task automatic t_stop;
    int tr, tc, td, ts, tdh, tdl, ton;
    pwr_req = 1'b1;
    cycles(2);
    check("R4 5V back on", {rst_en, pump_en, bypass_en}, 3'b110);
    stop_n = 1'b0;
    #1ns;
    check("R1 lines forced low at once", {rst_en, clk_en, dat_en}, 3'b000);
    run_down(3 * S + 10, 1'b0, tr, tc, td, ts, tdh, tdl, ton);
    check("R1 supply off after order", ts, 3 + 3 * S);
    cycles(OFF_CYC + 20);
    check("R1 stop overrides request", {pump_en, bypass_en, rst_en}, 3'b000);
    stop_n = 1'b1;
    cycles(2);
    check("R1 still off before sync", pump_en, 0);
    @(negedge clk);
    check("R1 back on at third edge", {rst_en, clk_en, dat_en, pump_en}, 4'b1111);
  endtask

  initial begin
    #(5ns * 150_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_power_on_5v;
    t_pump_5v;
    t_vsel_locked;
    t_down_by_req;
    t_3v;
    t_down_clk_low;
    t_stop;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule